// File: doc/BRIEF.md
# Self-Recovering Maximal-Length PN Sequence Generator

This block produces a serial pseudonoise bit stream from a six-stage linear feedback shift register. On every clock edge the register moves one place toward its last stage. The new first-stage bit is the exclusive-OR of the two highest stages, which gives the polynomial x^6 + x^5 + 1. The serial output is the last stage. The stream therefore repeats every 63 clocks, with 32 ones and 31 zeros in each period.

An XOR-feedback register that reaches the all-zero state stays there, because zero feeds zero back. A disturbed supply can leave the register in that state. A lockup guard prevents the stream from staying stuck:
- A detector ORs all register bits together.
- A recovery flop samples the detector output on every clock. Its output is low once it has captured an all-zero register.
- While the recovery flop output is low, the next edge loads ones into every stage instead of shifting.
- The recovery output is high for as long as this preset is active.

The serial output is a plain level that changes on every clock and has no handshake. The generator cannot be paused, so a valid/ready interface would have nothing to apply back-pressure to.

Top module: `pn_selfheal_gen`

## Requirements
- R1: After synchronous active-high reset with the default seed, every stage holds 1, `pn_o` is 1 and `recovering_o` is 0.
- R2: Outside a preset, each clock edge shifts stage k into stage k+1. The new stage 1 is stage 6 XOR stage 5, numbering stages 1 to 6 from input to output. `pn_o` is stage 6.
- R3: Starting from all ones, `pn_o` has a smallest period of exactly 63 clocks and holds 32 ones and 31 zeros in any 63 consecutive bits.
- R4: When the register is all zero at a clock edge, the recovery flop captures a low there. `recovering_o` is 1 in the cycle that follows.
- R5: When the recovery flop is low at a clock edge, that edge loads ones into every stage instead of shifting.
- R6: The parameter `SEED_VAL` sets the register value after reset. With a seed of all zeros, `recovering_o` is high for exactly the first two cycles after reset. After that, the output follows the sequence that starts from all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic-level shift clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pn_o | output | 1 | Serial pseudonoise bit, taken from the last stage |
| recovering_o | output | 1 | High while the all-ones preset is in effect |

## Verification
The bench builds three copies of the generator. All three use the default width of six and taps at stages six and five. The first uses the default all-ones seed. The second uses a seed of zero, so every reset places that copy directly in the lockup state. This exercises detection, the two-cycle preset and the return to the normal sequence without any special test input. The third uses the seed 0x2A, which shows that sequencing from an arbitrary start follows the shift rule. Random reset pulses hit all three copies at unrelated phases of the 63-bit period, so recovery is also repeated many times on the zero-seed copy.

// File: rtl/pn_pkg.sv
package pn_pkg;
  parameter int unsigned DEF_WIDTH  = 6;
  parameter int unsigned DEF_TAP_HI = 6;
  parameter int unsigned DEF_TAP_LO = 5;

  typedef enum logic {
    MODE_SHIFT  = 1'b0,
    MODE_PRESET = 1'b1
  } pn_mode_e;
endpackage

// File: rtl/pn_shift_core.sv
module pn_shift_core
  import pn_pkg::*;
#(
  parameter int unsigned WIDTH  = DEF_WIDTH,
  parameter int unsigned TAP_HI = DEF_TAP_HI,
  parameter int unsigned TAP_LO = DEF_TAP_LO,
  parameter logic [WIDTH-1:0] SEED_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  pn_mode_e         mode_i,
  output logic [WIDTH-1:0] state_o
);
  localparam int unsigned HI_IDX = TAP_HI - 1;
  localparam int unsigned LO_IDX = TAP_LO - 1;

  logic [WIDTH-1:0] stage_q;
  logic             feedback;

  assign feedback = stage_q[HI_IDX] ^ stage_q[LO_IDX];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= SEED_VAL;
    end else if (mode_i == MODE_PRESET) begin
      stage_q <= '1;
    end else begin
      stage_q <= {stage_q[WIDTH-2:0], feedback};
    end
  end

  assign state_o = stage_q;

  // A preset edge leaves every stage set.
  assert_preset_all_ones_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MODE_PRESET) |=> (stage_q == '1));

  // Stages move up by one place on a shift edge.
  assert_shift_moves_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MODE_SHIFT) |=> (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));

  // Stage 1 receives the XOR of the two tap stages.
  assert_feedback_tap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MODE_SHIFT) |=> (stage_q[0] == ($past(stage_q[HI_IDX]) ^ $past(stage_q[LO_IDX]))));
endmodule

// File: rtl/pn_zero_detect.sv
module pn_zero_detect #(
  parameter int unsigned WIDTH = pn_pkg::DEF_WIDTH
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             nonzero_o
);
  logic [WIDTH-1:0] any_set;

  assign any_set[0] = state_i[0];
  for (genvar g = 1; g < WIDTH; g++) begin : g_or_chain
    assign any_set[g] = any_set[g-1] | state_i[g];
  end

  assign nonzero_o = any_set[WIDTH-1];

  always_comb begin
    assert_detect_matches_R4: assert (nonzero_o == (state_i != '0));
  end
endmodule

// File: rtl/pn_recovery_latch.sv
module pn_recovery_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic nonzero_i,
  output logic run_n_o
);
  logic run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) run_q <= 1'b1;
    else       run_q <= nonzero_i;
  end

  assign run_n_o = run_q;

  assert_zero_captured_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !nonzero_i |=> !run_n_o);

  assert_nonzero_releases_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    nonzero_i |=> run_n_o);
endmodule

// File: rtl/pn_selfheal_gen.sv
module pn_selfheal_gen
  import pn_pkg::*;
#(
  parameter int unsigned WIDTH  = DEF_WIDTH,
  parameter int unsigned TAP_HI = DEF_TAP_HI,
  parameter int unsigned TAP_LO = DEF_TAP_LO,
  parameter logic [WIDTH-1:0] SEED_VAL = '1
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic pn_o,
  output logic recovering_o
);
  logic [WIDTH-1:0] state;
  logic             nonzero;
  logic             run_n;
  pn_mode_e         mode;

  assign mode = run_n ? MODE_SHIFT : MODE_PRESET;

  pn_shift_core #(
    .WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED_VAL(SEED_VAL)
  ) u_core (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (mode),
    .state_o(state)
  );

  pn_zero_detect #(.WIDTH(WIDTH)) u_detect (
    .state_i  (state),
    .nonzero_o(nonzero)
  );

  pn_recovery_latch u_latch (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .nonzero_i(nonzero),
    .run_n_o  (run_n)
  );

  assign pn_o         = state[WIDTH-1];
  assign recovering_o = ~run_n;

  // An all-zero register is never left unflagged on the next cycle.
  assert_lockup_flagged_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == '0) |=> recovering_o);

  // While flagged, the next cycle shows the register fully set.
  assert_flag_restores_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    recovering_o |=> (state == '1));

  // Coming out of reset, the register holds the seed.
  assert_seed_loaded_R6: assert property (@(posedge clk_i)
    rst_i |=> (state == SEED_VAL));
endmodule

// File: tb/pn_selfheal_gen_tb.sv
module pn_selfheal_gen_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic pn_d, rec_d, pn_z, rec_z, pn_s, rec_s;
  int   checks = 0;
  int   fails  = 0;
  logic [5:0] md, mz, ms;
  logic       qd, qz, qs;
  logic       bits [0:125];

  always #10 clk = ~clk;

  pn_selfheal_gen dut_i (.clk_i(clk), .rst_i(rst), .pn_o(pn_d), .recovering_o(rec_d));
  pn_selfheal_gen #(.SEED_VAL(6'h00)) dut_z (.clk_i(clk), .rst_i(rst), .pn_o(pn_z), .recovering_o(rec_z));
  pn_selfheal_gen #(.SEED_VAL(6'h2A)) dut_s (.clk_i(clk), .rst_i(rst), .pn_o(pn_s), .recovering_o(rec_s));

  function automatic logic [5:0] nxt(input logic [5:0] s);
    return {s[4:0], s[5] ^ s[4]};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic upd(input logic r, input logic [5:0] seed,
                     inout logic [5:0] s, inout logic q);
    logic nq;
    if (r) begin
      s = seed; q = 1'b1;
    end else begin
      nq = (s != 6'h00);
      s  = q ? nxt(s) : 6'h3F;
      q  = nq;
    end
  endtask

  task automatic cycle(input logic r);
    rst = r;
    @(posedge clk);
    upd(r, 6'h3F, md, qd);
    upd(r, 6'h00, mz, qz);
    upd(r, 6'h2A, ms, qs);
    @(negedge clk);
    chk("R2 default pn", pn_d, md[5]);
    chk("R4 default rec", rec_d, ~qd);
    chk("R5 zero-seed pn", pn_z, mz[5]);
    chk("R4 zero-seed rec", rec_z, ~qz);
    chk("R2 seed2A pn", pn_s, ms[5]);
    chk("R2 seed2A rec", rec_s, ~qs);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ones;
    logic seen_diff;
    void'($urandom(32'd4711));
    md = '1; mz = '0; ms = 6'h2A; qd = 1; qz = 1; qs = 1;
    @(negedge clk);
    cycle(1'b1);
    cycle(1'b1);
    // R1: reset state
    chk("R1 pn after reset", pn_d, 1'b1);
    chk("R1 rec after reset", rec_d, 1'b0);
    chk("R6 zero seed pn after reset", pn_z, 1'b0);
    bits[0] = pn_d;
    cycle(1'b0); bits[1] = pn_d;
    chk("R6 zero seed flagged first cycle", rec_z, 1'b1);
    cycle(1'b0); bits[2] = pn_d;
    chk("R6 zero seed flagged second cycle", rec_z, 1'b1);
    chk("R5 preset gives pn one", pn_z, 1'b1);
    cycle(1'b0); bits[3] = pn_d;
    chk("R6 zero seed flag cleared", rec_z, 1'b0);
    chk("R6 zero seed pn one", pn_z, 1'b1);
    for (int i = 4; i < 126; i++) begin
      cycle(1'b0);
      bits[i] = pn_d;
    end
    ones = 0;
    for (int i = 0; i < 63; i++) ones += int'(bits[i]);
    checks++;
    if (ones != 32) begin
      fails++;
      $display("FAIL R3 ones per period actual=%0d expected=32", ones);
    end
    for (int i = 0; i < 63; i++) chk("R3 repeat at 63", bits[i + 63], bits[i]);
    for (int p = 1; p < 63; p++) begin
      seen_diff = 1'b0;
      for (int i = 0; i < 63; i++) if (bits[i] != bits[i + p]) seen_diff = 1'b1;
      chk("R3 no shorter period", seen_diff, 1'b1);
    end
    for (int n = 0; n < 4000; n++) begin
      cycle(($urandom % 50) == 0);
    end
    cycle(1'b1);
    chk("R1 pn after late reset", pn_d, 1'b1);
    chk("R1 rec after late reset", rec_d, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule